// File: doc/BRIEF.md
# Event Counter with Status and Interrupt Flags

This block is a wrapping up/down event counter with a status word beside it. Single-cycle count pulses step the counter by one. The status word collects several kinds of information:

- sticky event flags: wrap forward, wrap backward, compare hit;
- a sign bit set by the wrap direction and a live direction bit;
- a capture handshake for a latched copy of the count;
- two interrupt-pending bits.

A simple register bus writes the status word. Writing a 1 clears a clearable flag. The status word is always presented on an output for reads.

A latch request copies the count into a holding register, provided the previous capture has been consumed. If it has not, the old value is kept and a loss flag is raised. A read strobe on the holding register consumes the capture. The interrupt line combines the compare-pending and control-pending bits, each behind its own enable.

Top module: `evtcnt_status`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) every status bit, the count and the latched value are 0. Status bits 31..10 always read 0.
- R2: When cnt_en_i and step_i are high at an edge, the count moves by +1 if step_up_i is 1 and by -1 if it is 0, wrapping modulo 2^CNT_W. With cnt_en_i low, the count holds.
- R3: Bit 1 sets on an enabled up step from all-ones to zero. Bit 0 sets on an enabled down step from zero to all-ones. Each clears only when a 1 is written to it.
- R4: Bit 3 becomes 1 on the step that sets bit 1 and 0 on the step that sets bit 0. Otherwise it holds.
- R5: Bit 2 sets at every edge where count_o equals cmp_val_i, and clears when a 1 is written to it.
- R6: Bit 8 reads 1 exactly while bit 2 is 1. Writing to bit 8 has no effect.
- R7: Bit 9 sets on ctl_irq_i and clears when a 1 is written to it.
- R8: A latch_req_i while bit 5 is 0 copies count_o into latch_o and sets bit 5. Bit 5 clears on out_rd_i or when a 1 is written to it.
- R9: A latch_req_i while bit 5 is 1 sets bit 6 and leaves latch_o unchanged. Bit 6 clears when a 1 is written to it.
- R10: In mode 01 (direction count), bit 4 equals step_up_i. In the other modes, bit 4 holds the direction of the last enabled step (1 = up).
- R11: Bit 7 reads 1 exactly when cnt_mode_i is 10 (single cycle) and cnt_en_i is 1.
- R12: irq_o = (bit 8 AND irq_en_match_i) OR (bit 9 AND irq_en_ctl_i).
- R13: When a flag's set event and a write-1 clear of that flag fall on the same edge, the flag ends up set.
- R14: Writes leave bits 3, 4, 7, 8 and 31..10 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en_i | input | 1 | Counter enable |
| cnt_mode_i | input | 2 | 00 up/down, 01 direction count, 10 single cycle, 11 as 00 |
| step_i | input | 1 | Count event pulse |
| step_up_i | input | 1 | Step direction, 1 = up |
| cmp_val_i | input | CNT_W | Compare value |
| latch_req_i | input | 1 | Latch event pulse |
| ctl_irq_i | input | 1 | Control-mode interrupt request pulse |
| wr_en_i | input | 1 | Status word write strobe |
| wr_data_i | input | 32 | Write data; 1 bits clear flags |
| out_rd_i | input | 1 | Read strobe of the latched value |
| irq_en_match_i | input | 1 | Enable of the compare interrupt |
| irq_en_ctl_i | input | 1 | Enable of the control interrupt |
| status_o | output | 32 | Status word |
| count_o | output | CNT_W | Current count |
| latch_o | output | CNT_W | Latched count |
| irq_o | output | 1 | Interrupt line |

## Verification
Every flag register feeds status_o directly, so a wrong flag shows on the port one edge after the event that caused it. The cycle-by-cycle model catches that at the first sample. A bad capture decision is different: it stays hidden in latch_o until the next latch request is accepted or refused, so the stimulus pairs requests with reads and write-clears in every order. A wrong count only surfaces when it reaches a wrap or a compare, so the counter is driven across zero many times with small compare values.

// File: rtl/evtcnt_pkg.sv
// Shared constants and types for the event counter status block.
// Bit positions are the software-visible layout of the status word.
package evtcnt_pkg;

    localparam int STAT_W = 32;

    localparam int POS_BOR  = 0;
    localparam int POS_CRY  = 1;
    localparam int POS_MAT  = 2;
    localparam int POS_SGN  = 3;
    localparam int POS_DIR  = 4;
    localparam int POS_LAT  = 5;
    localparam int POS_LOST = 6;
    localparam int POS_SGL  = 7;
    localparam int POS_MIRQ = 8;
    localparam int POS_CIRQ = 9;
    localparam int USED_W   = 10;

    // Write-1-clear flags kept by generic sticky cells
    localparam int NSTICKY = 5;
    localparam int IDX_BOR  = 0;
    localparam int IDX_CRY  = 1;
    localparam int IDX_MAT  = 2;
    localparam int IDX_LOST = 3;
    localparam int IDX_CIRQ = 4;
    localparam int STICKY_POS [NSTICKY] = '{POS_BOR, POS_CRY, POS_MAT, POS_LOST, POS_CIRQ};

    typedef enum logic [1:0] {
        MODE_UPDN   = 2'b00,
        MODE_DIRCNT = 2'b01,
        MODE_SINGLE = 2'b10,
        MODE_ALT    = 2'b11
    } cnt_mode_e;

endpackage

// File: rtl/evtcnt_core.sv
// Wrapping up/down counter.
// Produces single-cycle wrap pulses and remembers the last step direction.
// Assumes step_i is a one-cycle pulse already synchronised to clk.
module evtcnt_core #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             step_i,
    input  logic             up_i,
    output logic [CNT_W-1:0] count_o,
    output logic             wrap_up_o,
    output logic             wrap_dn_o,
    output logic             last_up_o
);

    logic step_ok;
    logic at_max;
    logic at_zero;

    // Qualify steps and detect the two wrap boundaries
    always_comb begin
        step_ok   = en_i & step_i;
        at_max    = &count_o;
        at_zero   = ~|count_o;
        wrap_up_o = step_ok & up_i & at_max;
        wrap_dn_o = step_ok & ~up_i & at_zero;
    end

    // Count register and last-direction memory
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o   <= '0;
            last_up_o <= 1'b0;
        end else if (step_ok) begin
            count_o   <= up_i ? count_o + 1'b1 : count_o - 1'b1;
            last_up_o <= up_i;
        end
    end

endmodule

// File: rtl/evtcnt_sticky.sv
// One write-1-clear flag.
// A hardware set event on the same edge as a clear wins.
module evtcnt_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);

    // Set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= 1'b0;
        else if (set_i)
            q_o <= 1'b1;
        else if (clr_i)
            q_o <= 1'b0;
    end

endmodule

// File: rtl/evtcnt_latch.sv
// Count capture with a one-entry handshake.
// A request is accepted only while the previous capture has been consumed.
// A refused request keeps the old value and reports a loss pulse.
module evtcnt_latch #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             rd_i,
    input  logic             wclr_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [CNT_W-1:0] latch_o,
    output logic             full_o,
    output logic             lost_o
);

    logic take;

    // Accept or refuse the incoming request
    always_comb begin
        take   = req_i & ~full_o;
        lost_o = req_i & full_o;
    end

    // Holding register, loaded only on an accepted request
    always_ff @(posedge clk) begin
        if (!rst_n)
            latch_o <= '0;
        else if (take)
            latch_o <= count_i;
    end

    // Full flag: set by a capture, cleared by a read or a write-1
    always_ff @(posedge clk) begin
        if (!rst_n)
            full_o <= 1'b0;
        else if (take)
            full_o <= 1'b1;
        else if (rd_i | wclr_i)
            full_o <= 1'b0;
    end

endmodule

// File: rtl/evtcnt_status.sv
// Event counter with status word and interrupt line.
// Assumes all pulse inputs are synchronous one-cycle strobes.
// The status word is combinationally readable at all times.
module evtcnt_status
    import evtcnt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en_i,
    input  logic [1:0]        cnt_mode_i,
    input  logic              step_i,
    input  logic              step_up_i,
    input  logic [CNT_W-1:0]  cmp_val_i,
    input  logic              latch_req_i,
    input  logic              ctl_irq_i,
    input  logic              wr_en_i,
    input  logic [STAT_W-1:0] wr_data_i,
    input  logic              out_rd_i,
    input  logic              irq_en_match_i,
    input  logic              irq_en_ctl_i,
    output logic [STAT_W-1:0] status_o,
    output logic [CNT_W-1:0]  count_o,
    output logic [CNT_W-1:0]  latch_o,
    output logic              irq_o
);

    cnt_mode_e          mode;
    logic               wrap_up;
    logic               wrap_dn;
    logic               last_up;
    logic               lat_full;
    logic               lat_lost;
    logic               sign_q;
    logic               dir_bit;
    logic               sgl_bit;
    logic [NSTICKY-1:0] st_set;
    logic [NSTICKY-1:0] st_q;

    assign mode = cnt_mode_e'(cnt_mode_i);

    evtcnt_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (cnt_en_i),
        .step_i    (step_i),
        .up_i      (step_up_i),
        .count_o   (count_o),
        .wrap_up_o (wrap_up),
        .wrap_dn_o (wrap_dn),
        .last_up_o (last_up)
    );

    evtcnt_latch #(.CNT_W(CNT_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (latch_req_i),
        .rd_i    (out_rd_i),
        .wclr_i  (wr_en_i & wr_data_i[POS_LAT]),
        .count_i (count_o),
        .latch_o (latch_o),
        .full_o  (lat_full),
        .lost_o  (lat_lost)
    );

    // Collect hardware set events of the sticky flags
    always_comb begin
        st_set           = '0;
        st_set[IDX_BOR]  = wrap_dn;
        st_set[IDX_CRY]  = wrap_up;
        st_set[IDX_MAT]  = (count_o == cmp_val_i);
        st_set[IDX_LOST] = lat_lost;
        st_set[IDX_CIRQ] = ctl_irq_i;
    end

    generate
        for (genvar i = 0; i < NSTICKY; i++) begin : g_sticky
            evtcnt_sticky u_flag (
                .clk   (clk),
                .rst_n (rst_n),
                .set_i (st_set[i]),
                .clr_i (wr_en_i & wr_data_i[STICKY_POS[i]]),
                .q_o   (st_q[i])
            );
        end
    endgenerate

    // Sign follows the direction of the most recent wrap
    always_ff @(posedge clk) begin
        if (!rst_n)
            sign_q <= 1'b0;
        else if (wrap_up)
            sign_q <= 1'b1;
        else if (wrap_dn)
            sign_q <= 1'b0;
    end

    // Live indicators that depend on mode and enable
    always_comb begin
        dir_bit = (mode == MODE_DIRCNT) ? step_up_i : last_up;
        sgl_bit = (mode == MODE_SINGLE) & cnt_en_i;
    end

    // Assemble the status word; unused upper bits stay zero
    always_comb begin
        status_o           = '0;
        status_o[POS_BOR]  = st_q[IDX_BOR];
        status_o[POS_CRY]  = st_q[IDX_CRY];
        status_o[POS_MAT]  = st_q[IDX_MAT];
        status_o[POS_SGN]  = sign_q;
        status_o[POS_DIR]  = dir_bit;
        status_o[POS_LAT]  = lat_full;
        status_o[POS_LOST] = st_q[IDX_LOST];
        status_o[POS_SGL]  = sgl_bit;
        status_o[POS_MIRQ] = st_q[IDX_MAT];
        status_o[POS_CIRQ] = st_q[IDX_CIRQ];
    end

    // Interrupt line: gated OR of the two pending bits
    always_comb begin
        irq_o = (st_q[IDX_MAT] & irq_en_match_i) | (st_q[IDX_CIRQ] & irq_en_ctl_i);
    end

endmodule

// File: rtl/evtcnt_status_chk.sv
// Property checker for evtcnt_status, attached by bind.
// Observes ports only.
module evtcnt_status_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_en_i,
    input logic             step_i,
    input logic             step_up_i,
    input logic             latch_req_i,
    input logic             ctl_irq_i,
    input logic [31:0]      status_o,
    input logic [CNT_W-1:0] count_o,
    input logic [CNT_W-1:0] latch_o
);

    logic up_wrap;
    logic dn_wrap;
    assign up_wrap = cnt_en_i & step_i & step_up_i & (&count_o);
    assign dn_wrap = cnt_en_i & step_i & ~step_up_i & ~(|count_o);

    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[31:10] == '0);

    a_r3_carry_sets: assert property (@(posedge clk) disable iff (!rst_n)
        up_wrap |=> status_o[1] && count_o == '0);

    a_r3_borrow_sets: assert property (@(posedge clk) disable iff (!rst_n)
        dn_wrap |=> status_o[0] && (&count_o));

    a_r4_sign_up: assert property (@(posedge clk) disable iff (!rst_n)
        up_wrap |=> status_o[3]);

    a_r4_sign_down: assert property (@(posedge clk) disable iff (!rst_n)
        dn_wrap |=> !status_o[3]);

    a_r6_mirq_tracks_match: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[8] == status_o[2]);

    a_r7_ctl_pending: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_irq_i |=> status_o[9]);

    a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_req_i && !status_o[5]) |=> status_o[5] && latch_o == $past(count_o));

    a_r9_lost_keeps_value: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_req_i && status_o[5]) |=> status_o[6] && $stable(latch_o));

    a_r2_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en_i |=> $stable(count_o));

endmodule

bind evtcnt_status evtcnt_status_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_en_i    (cnt_en_i),
    .step_i      (step_i),
    .step_up_i   (step_up_i),
    .latch_req_i (latch_req_i),
    .ctl_irq_i   (ctl_irq_i),
    .status_o    (status_o),
    .count_o     (count_o),
    .latch_o     (latch_o)
);

// File: tb/evtcnt_status_test.sv
// Bench for evtcnt_status: behavioural reference model compared every clock.
module evtcnt_status_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        en, step, up, lreq, ctl, wr, rd, ien_m, ien_c;
    logic [1:0]  mode;
    logic [31:0] cmp, wdata;
    logic [31:0] status, count, latchv;
    logic        irq;

    always #10 clk = ~clk;

    evtcnt_status uut (
        .clk(clk), .rst_n(rst_n), .cnt_en_i(en), .cnt_mode_i(mode),
        .step_i(step), .step_up_i(up), .cmp_val_i(cmp), .latch_req_i(lreq),
        .ctl_irq_i(ctl), .wr_en_i(wr), .wr_data_i(wdata), .out_rd_i(rd),
        .irq_en_match_i(ien_m), .irq_en_ctl_i(ien_c),
        .status_o(status), .count_o(count), .latch_o(latchv), .irq_o(irq)
    );

    integer n_chk = 0;
    integer n_fail = 0;
    bit     done = 0;

    // Reference state
    logic [31:0] m_cnt, m_lat;
    bit m_cry, m_bor, m_mat, m_sgn, m_dl, m_lost, m_cirq, m_up;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Advance the model by one edge using the inputs present at that edge
    task automatic model_step();
        logic [31:0] c;
        bit st, cry, bor, mev, cap, lost;
        if (!rst_n) begin
            m_cnt = 0; m_lat = 0; m_cry = 0; m_bor = 0; m_mat = 0; m_sgn = 0;
            m_dl = 0; m_lost = 0; m_cirq = 0; m_up = 0;
        end else begin
            c    = wr ? wdata : 32'h0;
            st   = step && en;
            cry  = st && up && (m_cnt == 32'hFFFF_FFFF);
            bor  = st && !up && (m_cnt == 32'h0);
            mev  = (m_cnt == cmp);
            cap  = lreq && !m_dl;
            lost = lreq && m_dl;
            m_cry  = cry  || (m_cry  && !c[1]);
            m_bor  = bor  || (m_bor  && !c[0]);
            m_mat  = mev  || (m_mat  && !c[2]);
            m_lost = lost || (m_lost && !c[6]);
            m_cirq = ctl  || (m_cirq && !c[9]);
            if (cry) m_sgn = 1;
            else if (bor) m_sgn = 0;
            if (cap) m_lat = m_cnt;
            m_dl = cap || (m_dl && !(c[5] || rd));
            if (st) begin
                m_cnt = up ? m_cnt + 1 : m_cnt - 1;
                m_up  = up;
            end
        end
    endtask

    task automatic compare_all();
        bit dir_e, sgl_e;
        dir_e = (mode == 2'b01) ? up : m_up;
        sgl_e = (mode == 2'b10) && en;
        chk("R1/R14 reserved bits", {10'h0, status[31:10]}, 32'h0);
        chk("R2 count", count, m_cnt);
        chk("R3 borrow bit0", status[0], m_bor);
        chk("R3 carry bit1", status[1], m_cry);
        chk("R5 match bit2", status[2], m_mat);
        chk("R4 sign bit3", status[3], m_sgn);
        chk("R10 direction bit4", status[4], dir_e);
        chk("R8 latched bit5", status[5], m_dl);
        chk("R8/R9 latch value", latchv, m_lat);
        chk("R9 lost bit6", status[6], m_lost);
        chk("R11 single bit7", status[7], sgl_e);
        chk("R6 match pending bit8", status[8], m_mat);
        chk("R7 ctl pending bit9", status[9], m_cirq);
        chk("R12 irq", irq, (m_mat && ien_m) || (m_cirq && ien_c));
    endtask

    // One clock: update model at the edge, compare 5 ns later, clear pulses
    task automatic tick();
        @(posedge clk);
        model_step();
        #5;
        compare_all();
        step = 0; lreq = 0; ctl = 0; wr = 0; rd = 0; wdata = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        #3000000;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 0; en = 1; mode = 2'b00; step = 0; up = 1; lreq = 0; ctl = 0;
        wr = 0; rd = 0; wdata = 0; cmp = 32'h80; ien_m = 1; ien_c = 1;
        tick(); tick();
        chk("R1 reset status", status, {27'h0, 1'b0, 4'h0});
        rst_n = 1;
        tick();

        // R2: up steps, then disabled step holds
        repeat (3) begin step = 1; up = 1; tick(); end
        chk("R2 count after three up steps", count, 32'd3);
        en = 0; step = 1; tick();
        chk("R2 count held while disabled", count, 32'd3);
        en = 1;

        // R3/R4: down through zero
        repeat (4) begin step = 1; up = 0; tick(); end
        chk("R3 borrow after wrap down", status[0], 1'b1);
        chk("R4 sign after wrap down", status[3], 1'b0);
        step = 1; up = 1; tick();
        chk("R3 carry after wrap up", status[1], 1'b1);
        chk("R4 sign after wrap up", status[3], 1'b1);
        wr = 1; wdata = 32'h3; tick();
        chk("R3 flags cleared by write", status[1:0], 2'b00);

        // R13: borrow event coincides with write-1 clear of borrow
        step = 1; up = 0; wr = 1; wdata = 32'h1; tick();
        chk("R13 set beats clear", status[0], 1'b1);

        // R14: writing all ones leaves bits 3,4,7,8 and upper bits alone
        mode = 2'b10; tick();
        wr = 1; wdata = 32'hFFFF_FFFF; tick();
        chk("R14 sign unchanged by write", status[3], 1'b0);
        chk("R14 single unchanged by write", status[7], 1'b1);
        mode = 2'b00;

        // R5/R6/R12: compare hit
        cmp = count; tick(); tick();
        chk("R5 match set", status[2], 1'b1);
        chk("R12 irq on match", irq, 1'b1);
        ien_m = 0; tick();
        chk("R12 irq gated", irq, 1'b0);
        wr = 1; wdata = 32'h104; tick();
        chk("R13 match stays while equal", status[2], 1'b1);
        cmp = 32'h55; tick();
        wr = 1; wdata = 32'h4; tick();
        chk("R6 pending drops with match", status[8], 1'b0);
        ien_m = 1;

        // R8/R9: latch handshake
        step = 1; up = 1; tick();
        lreq = 1; tick();
        chk("R8 latch captured", status[5], 1'b1);
        step = 1; up = 1; tick();
        lreq = 1; tick();
        chk("R9 loss flagged", status[6], 1'b1);
        rd = 1; tick();
        chk("R8 cleared by read", status[5], 1'b0);
        wr = 1; wdata = 32'h40; tick();
        chk("R9 cleared by write", status[6], 1'b0);
        lreq = 1; rd = 1; tick();
        wr = 1; wdata = 32'h20; tick();
        chk("R8 cleared by write", status[5], 1'b0);

        // R7: control interrupt
        ctl = 1; tick();
        chk("R7 ctl pending", status[9], 1'b1);
        wr = 1; wdata = 32'h200; tick();
        chk("R7 ctl acknowledged", status[9], 1'b0);

        // R10/R11: modes
        mode = 2'b01; up = 0; tick(); up = 1; tick(); up = 0; tick();
        mode = 2'b10; en = 1; tick(); en = 0; tick(); en = 1;
        mode = 2'b11; tick();

        // Mixed random traffic around zero
        for (int i = 0; i < 3000; i++) begin
            step  = ($urandom % 3) != 0;
            up    = $urandom % 2;
            en    = ($urandom % 8) != 0;
            mode  = $urandom % 4;
            lreq  = ($urandom % 6) == 0;
            rd    = ($urandom % 6) == 0;
            ctl   = ($urandom % 10) == 0;
            wr    = ($urandom % 5) == 0;
            wdata = $urandom;
            ien_m = $urandom % 2;
            ien_c = $urandom % 2;
            if (($urandom % 40) == 0) cmp = ($urandom % 7) - 3;
            tick();
        end

        finish_run();
    end

endmodule